// File: doc/BRIEF.md
# Segment Protection and Limit Checker

This block sits at the head of address translation. Each cycle it can accept one access, given as an address that already has the segment base added, a byte count, and a kind (read, write or fetch). It also takes the attributes of the selected segment and the processor mode bits. In legacy protected mode it checks the segment's permissions and its limit. In real mode, and when a 64-bit code segment runs in long mode, it skips these checks.

One cycle after the request, the block raises a response strobe. The response carries a fault flag, a flag asking for a paging lookup, and the address. When paging is off, that address is the physical address. The limit test treats a segment whose limit is numerically below its base as wrapped. It handles this case separately for expand-up and for expand-down segments.

Top module: `segchk_front`

## Requirements
- R1: With `mode_pe` low, the response shows no fault and no paging request, and `rsp_addr` equals the request address. Segment inputs and `mode_pg` have no effect.
- R2: With `mode_pe`, `mode_lma` and `mode_cs_long` all high, no permission or limit fault is raised.
- R3: When checks apply, a write (`req_kind` = 2'b01) to a segment with `seg_writable` low faults.
- R4: When checks apply, a read (`req_kind` = 2'b00 or 2'b11) to a segment with `seg_readable` low faults. A fetch (`req_kind` = 2'b10) never raises a permission fault.
- R5: Expand-up segment with limit >= base: the access faults when limit < address + size.
- R6: Expand-up segment with limit < base: the access faults only when limit < address + size and address < base.
- R7: Expand-down segment with limit < base: the access faults when address <= limit or address + size >= base.
- R8: Expand-down segment with limit >= base: the access faults when address <= limit and address + size >= base.
- R9: With `mode_pe` and `mode_pg` high and no fault, `rsp_need_paging` is set. Otherwise it is clear, and `rsp_addr` is the physical address. Fault and paging request are never both set.
- R10: The response registers one cycle after `req_valid`. `rsp_fault` and `rsp_need_paging` are low whenever `rsp_valid` is low. `rsp_fault_code` is always zero.
- R11: After reset, `rsp_valid`, `rsp_fault` and `rsp_need_paging` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access present this cycle |
| req_addr | input | ADDR_W | Address with segment base applied |
| req_size | input | SIZE_W | Access length in bytes |
| req_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 read |
| seg_readable | input | 1 | Segment permits data reads |
| seg_writable | input | 1 | Segment permits writes |
| seg_expand_down | input | 1 | Segment grows downward |
| seg_base | input | ADDR_W | Segment base |
| seg_limit | input | ADDR_W | Segment limit |
| mode_pe | input | 1 | Protection enabled |
| mode_pg | input | 1 | Paging enabled |
| mode_lma | input | 1 | Long mode active |
| mode_cs_long | input | 1 | Code segment is 64-bit |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 1 | General protection fault |
| rsp_fault_code | output | FAULT_CODE_W | Fault error code, zero |
| rsp_need_paging | output | 1 | Address must go through paging |
| rsp_addr | output | ADDR_W | Checked address |

## Verification
The bench builds the block with a 4-bit address and a 2-bit size. With these widths the bench can try every combination of base, limit, address, size and growth direction. This covers all four limit formulas, both sides of every wrapped boundary, and the edge where address + size carries past the top of the address space. A second sweep walks every combination of mode bits, permission bits and access kind. It does this against one geometry that passes the limit test and one that fails it.

// File: rtl/segchk_pkg.sv
package segchk_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  typedef struct packed {
    logic fault;
    logic paging;
  } verdict_t;
endpackage

// File: rtl/segchk_perm.sv
module segchk_perm
  import segchk_pkg::*;
(
  input  logic [1:0] kind,
  input  logic       readable,
  input  logic       writable,
  output logic       wr_deny,
  output logic       rd_deny,
  output logic       perm_fault
);
  logic is_write, is_fetch;

  always_comb begin
    is_write   = (kind == ACC_WRITE);
    is_fetch   = (kind == ACC_FETCH);
    wr_deny    = is_write && !writable;
    // anything that is neither write nor fetch counts as a data read
    rd_deny    = !is_write && !is_fetch && !readable;
    perm_fault = wr_deny || rd_deny;
  end
endmodule

// File: rtl/segchk_limit.sv
module segchk_limit #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  input  logic              expand_down,
  output logic              wrapped,
  output logic              limit_fault
);
  localparam int SUM_W = ADDR_W + 1;

  function automatic logic [SUM_W-1:0] span_end(input logic [ADDR_W-1:0] a,
                                                 input logic [SIZE_W-1:0] s);
    return {1'b0, a} + SUM_W'(s);
  endfunction

  function automatic logic up_violation(input logic [ADDR_W-1:0] a,
                                        input logic [SUM_W-1:0]  e,
                                        input logic [ADDR_W-1:0] b,
                                        input logic [ADDR_W-1:0] l);
    logic past_top;
    past_top = ({1'b0, l} < e);
    if (l >= b) return past_top;
    return past_top && (a < b);
  endfunction

  function automatic logic down_violation(input logic [ADDR_W-1:0] a,
                                          input logic [SUM_W-1:0]  e,
                                          input logic [ADDR_W-1:0] b,
                                          input logic [ADDR_W-1:0] l);
    logic low_hit, high_hit;
    low_hit  = (a <= l);
    high_hit = (e >= {1'b0, b});
    if (l < b) return low_hit || high_hit;
    return low_hit && high_hit;
  endfunction

  logic [SUM_W-1:0] end_addr;
  logic             up_bad, down_bad;

  always_comb begin
    end_addr    = span_end(addr, size);
    wrapped     = (limit < base);
    up_bad      = up_violation(addr, end_addr, base, limit);
    down_bad    = down_violation(addr, end_addr, base, limit);
    limit_fault = expand_down ? down_bad : up_bad;
  end
endmodule

// File: rtl/segchk_route.sv
module segchk_route
  import segchk_pkg::*;
(
  input  logic     pe,
  input  logic     pg,
  input  logic     lma,
  input  logic     cs_long,
  input  logic     perm_fault,
  input  logic     limit_fault,
  output logic     checks_on,
  output verdict_t verdict
);
  always_comb begin
    checks_on      = pe && !(lma && cs_long);
    verdict.fault  = checks_on && (perm_fault || limit_fault);
    verdict.paging = pe && pg && !verdict.fault;
  end
endmodule

// File: rtl/segchk_front.sv
module segchk_front
  import segchk_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int SIZE_W       = 4,
  parameter int FAULT_CODE_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [SIZE_W-1:0]       req_size,
  input  logic [1:0]              req_kind,
  input  logic                    seg_readable,
  input  logic                    seg_writable,
  input  logic                    seg_expand_down,
  input  logic [ADDR_W-1:0]       seg_base,
  input  logic [ADDR_W-1:0]       seg_limit,
  input  logic                    mode_pe,
  input  logic                    mode_pg,
  input  logic                    mode_lma,
  input  logic                    mode_cs_long,
  output logic                    rsp_valid,
  output logic                    rsp_fault,
  output logic [FAULT_CODE_W-1:0] rsp_fault_code,
  output logic                    rsp_need_paging,
  output logic [ADDR_W-1:0]       rsp_addr
);
  logic     ev_wr_deny, ev_rd_deny, ev_perm_fault;
  logic     ev_wrapped, ev_limit_fault;
  logic     ev_checks_on;
  verdict_t ev_verdict;

  segchk_perm u_perm (
    .kind       (req_kind),
    .readable   (seg_readable),
    .writable   (seg_writable),
    .wr_deny    (ev_wr_deny),
    .rd_deny    (ev_rd_deny),
    .perm_fault (ev_perm_fault)
  );

  segchk_limit #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_limit (
    .addr        (req_addr),
    .size        (req_size),
    .base        (seg_base),
    .limit       (seg_limit),
    .expand_down (seg_expand_down),
    .wrapped     (ev_wrapped),
    .limit_fault (ev_limit_fault)
  );

  segchk_route u_route (
    .pe          (mode_pe),
    .pg          (mode_pg),
    .lma         (mode_lma),
    .cs_long     (mode_cs_long),
    .perm_fault  (ev_perm_fault),
    .limit_fault (ev_limit_fault),
    .checks_on   (ev_checks_on),
    .verdict     (ev_verdict)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid       <= 1'b0;
      rsp_fault       <= 1'b0;
      rsp_need_paging <= 1'b0;
      rsp_addr        <= '0;
    end else begin
      rsp_valid       <= req_valid;
      rsp_fault       <= req_valid && ev_verdict.fault;
      rsp_need_paging <= req_valid && ev_verdict.paging;
      if (req_valid) rsp_addr <= req_addr;
    end
  end

  // every fault is a general protection fault with error code zero
  assign rsp_fault_code = '0;

  assert_strobe_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_fault && !rsp_need_paging));

  assert_real_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !mode_pe) |=>
      (!rsp_fault && !rsp_need_paging && rsp_addr == $past(req_addr)));

  assert_long_skip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode_pe && mode_lma && mode_cs_long) |=> !rsp_fault);

  assert_write_deny_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ev_checks_on && req_kind == ACC_WRITE && !seg_writable) |=> rsp_fault);

  assert_fetch_no_perm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_kind == ACC_FETCH) |-> !ev_perm_fault);

  assert_wrap_up_above_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!seg_expand_down && ev_wrapped && req_addr >= seg_base) |-> !ev_limit_fault);

  assert_paging_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_fault && rsp_need_paging));

  assert_paging_needs_pg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !(mode_pe && mode_pg)) |=> !rsp_need_paging);
endmodule

// File: tb/segchk_front_test.sv
`timescale 1ns/1ps
module segchk_front_test;
  localparam int AW = 4;
  localparam int SW = 2;
  localparam int FW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [SW-1:0] req_size = '0;
  logic [1:0] req_kind = 2'b00;
  logic seg_readable = 1'b1, seg_writable = 1'b1, seg_expand_down = 1'b0;
  logic [AW-1:0] seg_base = '0, seg_limit = '0;
  logic mode_pe = 1'b0, mode_pg = 1'b0, mode_lma = 1'b0, mode_cs_long = 1'b0;
  logic rsp_valid, rsp_fault, rsp_need_paging;
  logic [FW-1:0] rsp_fault_code;
  logic [AW-1:0] rsp_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  segchk_front #(.ADDR_W(AW), .SIZE_W(SW), .FAULT_CODE_W(FW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_kind(req_kind), .seg_readable(seg_readable),
    .seg_writable(seg_writable), .seg_expand_down(seg_expand_down),
    .seg_base(seg_base), .seg_limit(seg_limit), .mode_pe(mode_pe),
    .mode_pg(mode_pg), .mode_lma(mode_lma), .mode_cs_long(mode_cs_long),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_fault_code(rsp_fault_code),
    .rsp_need_paging(rsp_need_paging), .rsp_addr(rsp_addr)
  );

  // bench model of the limit rule, written on plain integers
  function automatic bit model_limit(int a, int s, int b, int l, bit down);
    int last;
    last = a + s;
    if (!down) begin
      if (b <= l) return last > l;
      return (last > l) && (a < b);
    end
    if (b > l) return (a <= l) || (last >= b);
    return (a <= l) && (last >= b);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (a=%0d s=%0d b=%0d l=%0d dn=%0b k=%0d pe=%0b pg=%0b)",
               tag, what, act, exp, req_addr, req_size, seg_base, seg_limit,
               seg_expand_down, req_kind, mode_pe, mode_pg);
    end
  endtask

  // drive one access, then sample one cycle later after the edge
  task automatic issue(string tag, bit exp_fault, bit exp_pg);
    @(negedge clk);
    req_valid = 1'b1;
    @(posedge clk);
    #1;
    check(tag, "valid", rsp_valid, 1);
    check(tag, "fault", rsp_fault, exp_fault);
    check(tag, "paging", rsp_need_paging, exp_pg);
    check(tag, "addr", rsp_addr, req_addr);
    check("R10", "code", rsp_fault_code, 0);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R11", "reset valid", rsp_valid, 0);
    check("R11", "reset fault", rsp_fault, 0);
    check("R11", "reset paging", rsp_need_paging, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // sweep 1: every geometry, checks active, readable and writable
    mode_pe = 1'b1;
    for (int dn = 0; dn < 2; dn++)
      for (int b = 0; b < 16; b++)
        for (int l = 0; l < 16; l++)
          for (int a = 0; a < 16; a++)
            for (int s = 0; s < 4; s++) begin
              bit f;
              string tag;
              @(negedge clk);
              seg_expand_down = dn[0]; seg_base = AW'(b); seg_limit = AW'(l);
              req_addr = AW'(a); req_size = SW'(s); mode_pg = a[0];
              req_kind = 2'(s);
              req_valid = 1'b1;
              f = model_limit(a, s, b, l, dn[0]);
              if (dn == 0) tag = (l >= b) ? "R5" : "R6";
              else tag = (l < b) ? "R7" : "R8";
              @(posedge clk);
              #1;
              check(tag, "fault", rsp_fault, f);
              check("R9", "paging", rsp_need_paging, (!f) && a[0]);
            end
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);
    #1;
    check("R10", "idle valid", rsp_valid, 0);
    check("R10", "idle fault", rsp_fault, 0);

    // sweep 2: modes, permissions and kinds on a passing and a failing geometry
    for (int g = 0; g < 2; g++)
      for (int m = 0; m < 16; m++)
        for (int p = 0; p < 4; p++)
          for (int k = 0; k < 4; k++) begin
            bit on, permf, limf, f, pgx;
            string tag;
            @(negedge clk);
            seg_expand_down = 1'b0; seg_base = 4'd0;
            seg_limit = (g == 0) ? 4'd15 : 4'd2;
            req_addr = (g == 0) ? 4'd0 : 4'd3;
            req_size = 2'd1;
            mode_pe = m[0]; mode_pg = m[1]; mode_lma = m[2]; mode_cs_long = m[3];
            seg_readable = p[0]; seg_writable = p[1];
            req_kind = 2'(k);
            on = m[0] && !(m[2] && m[3]);
            permf = (k == 1) ? !p[1] : ((k == 2) ? 1'b0 : !p[0]);
            limf = (g == 1);
            f = on && (permf || limf);
            pgx = m[0] && m[1] && !f;
            if (!m[0]) tag = "R1";
            else if (!on) tag = "R2";
            else if (k == 1) tag = "R3";
            else tag = "R4";
            issue(tag, f, pgx);
          end

    // a faulting access followed by an idle cycle
    mode_pe = 1'b1; mode_lma = 1'b0; seg_writable = 1'b0; req_kind = 2'b01;
    issue("R3", 1'b1, 1'b0);
    @(posedge clk);
    #1;
    check("R10", "idle after fault", rsp_fault, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule